// File: doc/BRIEF.md
# Stack Frame Link/Unlink Sequencer

This block carries out the two frame-pointer instructions of a 32-bit processor that has eight address registers. Register index 7 is the stack pointer. The link operation saves an address register on the stack and makes that register the new frame pointer. It then moves the stack pointer by a signed 16-bit displacement, which reserves space for local variables. The unlink operation reverses this. The stack pointer is set back from the frame pointer, and the saved frame pointer is popped into the register.

An operation enters through a valid/ready handshake on `op_valid`/`op_ready`, carrying a 16-bit opcode and the displacement. `op_ready` is high only while the block is idle. A request is taken on a clock edge where `op_valid` and `op_ready` are both high. A caller that keeps `op_valid` asserted has the request taken once the block returns to idle. A request that is withdrawn before then has no effect.

The block reads and writes the register file through one combinational read port and one write port. It makes one 32-bit memory access per operation over a request/acknowledge pair. When it finishes, it pulses `done` for one cycle and reports the instruction's cycle cost on `cost`.

Top module: `frame_link_unit`

## Requirements
- R1: Bits [15:4] of the opcode select the operation: 0x4E5 means a valid operation, and bit 3 chooses between link (0) and unlink (1). Bits [2:0] give the address register. A taken request with any other opcode writes nothing, makes no memory access and gives no `done`.
- R2: Link writes the named register's 32-bit value to memory at the stack pointer minus 4.
- R3: After link, the named register holds the old stack pointer minus 4. The stack pointer holds that value plus the sign-extended displacement.
- R4: Link on register 7 pushes the old stack pointer minus 4. It leaves the stack pointer at the old stack pointer minus 4 plus the displacement.
- R5: Unlink reads the word at the address held in the named register. It sets the stack pointer to that address plus 4 and then loads the word into the named register.
- R6: Unlink on register 7 leaves register 7 holding the word read from memory.
- R7: During the `done` cycle, `cost` is 16 for link and 12 for unlink. Outside that cycle it is 0.
- R8: `op_ready` is high exactly when `busy` is low. A request raised and withdrawn while busy has no effect.
- R9: `mem_req` stays high, with a stable address, until `mem_ack`. A register write never happens in the same cycle as a memory request.
- R10: `done` lasts one cycle. It comes 4 plus the number of memory wait cycles after the accepting edge, and `busy` is low in the following cycle.
- R11: After reset, `busy`, `done`, `mem_req` and `rf_we` are low and `op_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Request present |
| op_ready | output | 1 | Block idle, request can be taken |
| op_code | input | 16 | Opcode of the request |
| op_disp | input | 16 | Signed displacement for link |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| cost | output | 5 | Cycle cost of the finished instruction, valid with done |
| rf_raddr | output | 3 | Register read index |
| rf_rdata | input | 32 | Register read data (combinational) |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 3 | Register write index |
| rf_wdata | output | 32 | Register write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The sequence after an accepting edge is fixed: two register-read cycles, the memory request cycles up to and including the acknowledge, then two write cycles. `done` is therefore due exactly 4 plus the number of wait cycles after acceptance. The driver stamps each expected item with that due cycle. The monitor compares the stamp against a free-running cycle counter read half a period after the edge. The second register write commits on the edge after `done`, so the register and memory contents are compared one cycle later than `done`. Acknowledge latencies of 0 to 3 cycles are used so that the due-cycle rule is tested with and without waits.

// File: rtl/frame_pkg.sv
package frame_pkg;
  localparam int ADDR_REGS = 8;
  localparam int IDX_W     = $clog2(ADDR_REGS);
  localparam logic [IDX_W-1:0] SP_IDX = IDX_W'(ADDR_REGS - 1);
  localparam logic [11:0] OP_FAMILY = 12'h4E5;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_RD_SP,
    SEQ_RD_REG,
    SEQ_MEM,
    SEQ_WR_A,
    SEQ_WR_B
  } seq_state_t;
endpackage

// File: rtl/frame_op_decode.sv
module frame_op_decode
  import frame_pkg::*;
(
  input  logic [15:0]      opcode,
  output logic             op_ok,
  output logic             op_unlk,
  output logic [IDX_W-1:0] op_reg
);
  always_comb begin
    op_ok   = (opcode[15:4] == OP_FAMILY);
    op_unlk = opcode[3];
    op_reg  = opcode[IDX_W-1:0];
  end
endmodule

// File: rtl/frame_seq_ctrl.sv
module frame_seq_ctrl
  import frame_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic       ack,
  output seq_state_t state
);
  seq_state_t nxt;

  always_comb begin
    nxt = state;
    case (state)
      SEQ_IDLE:   if (take) nxt = SEQ_RD_SP;
      SEQ_RD_SP:  nxt = SEQ_RD_REG;
      SEQ_RD_REG: nxt = SEQ_MEM;
      SEQ_MEM:    if (ack) nxt = SEQ_WR_A;
      SEQ_WR_A:   nxt = SEQ_WR_B;
      SEQ_WR_B:   nxt = SEQ_IDLE;
      default:    nxt = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state <= SEQ_IDLE;
    else        state <= nxt;

  assert_wait_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_MEM && !ack) |=> (state == SEQ_MEM));
  assert_done_leaves_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_WR_B) |=> (state == SEQ_IDLE));
endmodule

// File: rtl/frame_link_unit.sv
module frame_link_unit
  import frame_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int DISP_W      = 16,
  parameter int COST_W      = 5,
  parameter int LINK_COST   = 16,
  parameter int UNLINK_COST = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [15:0]       op_code,
  input  logic [DISP_W-1:0] op_disp,
  output logic              busy,
  output logic              done,
  output logic [COST_W-1:0] cost,
  output logic [IDX_W-1:0]  rf_raddr,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam logic [DATA_W-1:0] WORD_BYTES = DATA_W'(DATA_W / 8);

  logic             dec_ok, dec_unlk;
  logic [IDX_W-1:0] dec_reg;
  logic             take;
  seq_state_t       state;

  logic              unlk_q;
  logic [IDX_W-1:0]  reg_q;
  logic [DISP_W-1:0] disp_q;
  logic [DATA_W-1:0] sp_q, addr_q, data_q;
  logic [DATA_W-1:0] disp_ext;

  frame_op_decode u_dec (
    .opcode (op_code),
    .op_ok  (dec_ok),
    .op_unlk(dec_unlk),
    .op_reg (dec_reg)
  );

  frame_seq_ctrl u_seq (
    .clk  (clk),
    .rst_n(rst_n),
    .take (take),
    .ack  (mem_ack),
    .state(state)
  );

  assign op_ready = (state == SEQ_IDLE);
  assign busy     = !op_ready;
  assign take     = op_valid && op_ready && dec_ok;
  assign disp_ext = {{(DATA_W-DISP_W){disp_q[DISP_W-1]}}, disp_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlk_q <= 1'b0;
      reg_q  <= '0;
      disp_q <= '0;
      sp_q   <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      case (state)
        SEQ_IDLE: if (take) begin
          unlk_q <= dec_unlk;
          reg_q  <= dec_reg;
          disp_q <= op_disp;
        end
        SEQ_RD_SP: sp_q <= rf_rdata;
        SEQ_RD_REG: begin
          if (unlk_q) begin
            addr_q <= rf_rdata;
          end else begin
            addr_q <= sp_q - WORD_BYTES;
            data_q <= (reg_q == SP_IDX) ? (sp_q - WORD_BYTES) : rf_rdata;
          end
        end
        SEQ_MEM: if (mem_ack && unlk_q) data_q <= mem_rdata;
        default: ;
      endcase
    end
  end

  assign rf_raddr  = (state == SEQ_RD_SP) ? SP_IDX : reg_q;
  assign mem_req   = (state == SEQ_MEM);
  assign mem_we    = !unlk_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = data_q;

  always_comb begin
    rf_we    = 1'b0;
    rf_waddr = reg_q;
    rf_wdata = addr_q;
    if (state == SEQ_WR_A) begin
      rf_we    = 1'b1;
      rf_waddr = unlk_q ? SP_IDX : reg_q;
      rf_wdata = unlk_q ? (addr_q + WORD_BYTES) : addr_q;
    end else if (state == SEQ_WR_B) begin
      rf_we    = 1'b1;
      rf_waddr = unlk_q ? reg_q : SP_IDX;
      rf_wdata = unlk_q ? data_q : (addr_q + disp_ext);
    end
  end

  assign done = (state == SEQ_WR_B);
  assign cost = !done ? '0 : (unlk_q ? COST_W'(UNLINK_COST) : COST_W'(LINK_COST));

  assert_req_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rf_we, mem_req}));
  assert_single_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  assert_take_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && op_code[15:4] == OP_FAMILY) |=> busy);
  assert_write_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> busy);
  assert_cost_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cost == COST_W'(LINK_COST) || cost == COST_W'(UNLINK_COST)));
endmodule

// File: tb/frame_link_unit_test.sv
module frame_link_unit_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0][31:0] regs;
    logic             chk_mem;
    logic [31:0]      mem_a;
    logic [31:0]      mem_v;
    logic [4:0]       cost;
    int               due;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic op_valid = 0;
  logic [15:0] op_code = 0, op_disp = 0;
  logic op_ready, busy, done;
  logic [4:0] cost;
  logic [2:0] rf_raddr, rf_waddr;
  logic [31:0] rf_rdata, rf_wdata;
  logic rf_we, mem_req, mem_we, mem_ack = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  logic [31:0] regs [8];
  logic [31:0] mem [64];
  int cyc = 0, waits = 0, wcnt = 0;
  int checks = 0, fails = 0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_link_unit uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .op_disp(op_disp), .busy(busy), .done(done), .cost(cost),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  assign rf_rdata  = regs[rf_raddr];
  assign mem_rdata = mem[mem_addr[7:2]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rf_we) regs[rf_waddr] <= rf_wdata;
    if (mem_req && mem_ack && mem_we) mem[mem_addr[7:2]] <= mem_wdata;
  end

  always @(negedge clk) begin
    if (!mem_req) begin mem_ack <= 0; wcnt <= 0; end
    else if (wcnt >= waits) mem_ack <= 1;
    else wcnt <= wcnt + 1;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_mem(input logic [31:0] a);
    return mem[a[7:2]];
  endfunction

  // Driver: computes expectations from the requirements, then issues the request
  task automatic run_op(input logic [15:0] opc, input logic [15:0] d, input int w, input bit poke_busy);
    exp_t e;
    logic [2:0] n;
    logic [31:0] sp, na, v, a;
    n = opc[2:0];
    for (int i = 0; i < 8; i++) e.regs[i] = regs[i];
    e.chk_mem = 0; e.mem_a = 0; e.mem_v = 0;
    if (!opc[3]) begin
      sp = regs[7]; na = sp - 4;
      v = (n == 3'd7) ? na : regs[n];       // R2, R4
      e.regs[n] = na;                       // R3
      e.regs[7] = na + {{16{d[15]}}, d};    // R3, R4
      e.chk_mem = 1; e.mem_a = na; e.mem_v = v;
      e.cost = 5'd16;
    end else begin
      a = regs[n];
      e.regs[7] = a + 4;                    // R5
      e.regs[n] = rd_mem(a);                // R5, R6
      e.cost = 5'd12;
    end
    waits = w;
    @(negedge clk);
    op_code = opc; op_disp = d; op_valid = 1;
    e.due = cyc + 5 + w;                    // R10
    q.push_back(e);
    @(negedge clk);
    op_valid = 0;
    if (poke_busy) begin
      @(negedge clk);
      check(op_ready == 0, "R8 ready while busy", op_ready, 0);
      op_code = 16'h4E50; op_valid = 1;     // R8: request raised and withdrawn while busy
      @(negedge clk);
      op_valid = 0;
    end
    wait (q.size() == 0);
    repeat (3) @(negedge clk);
  endtask

  // Monitor: compares completions against the scoreboard
  initial begin
    exp_t e;
    forever begin
      @(negedge clk); #1;
      if (rst_n && done) begin
        if (q.size() == 0) begin
          check(0, "R1/R8 unexpected done", 1, 0);
        end else begin
          e = q[0];
          check(cyc == e.due, "R10 done timing", cyc, e.due);
          check(cost == e.cost, "R7 cost", cost, e.cost);
          @(negedge clk); #1;
          check(!done && !busy && op_ready, "R10 single done", done, 0);
          for (int i = 0; i < 8; i++)
            check(regs[i] === e.regs[i], $sformatf("R3/R5 reg %0d", i), regs[i], e.regs[i]);
          if (e.chk_mem)
            check(rd_mem(e.mem_a) === e.mem_v, "R2/R4 pushed word", rd_mem(e.mem_a), e.mem_v);
          void'(q.pop_front());
        end
      end else if (rst_n) begin
        check(cost == 0 || done, "R7 cost idle", cost, 0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=<20000", cyc);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] snap [8];
    for (int i = 0; i < 64; i++) mem[i] = 32'hA500_0000 + i;
    for (int i = 0; i < 7; i++) regs[i] = 32'h40 + 32'(i) * 8;
    regs[7] = 32'hC0;
    repeat (2) @(negedge clk);
    // R11 reset state
    check(op_ready == 1, "R11 ready", op_ready, 1);
    check(busy == 0, "R11 busy", busy, 0);
    check(done == 0, "R11 done", done, 0);
    check(mem_req == 0, "R11 mem_req", mem_req, 0);
    check(rf_we == 0, "R11 rf_we", rf_we, 0);
    rst_n = 1;
    @(negedge clk);
    run_op(16'h4E56, 16'hFFF8, 0, 0);   // R2 R3 link r6, negative disp
    run_op(16'h4E5E, 16'h0000, 2, 0);   // R5 unlink r6 restores
    run_op(16'h4E57, 16'hFFF0, 1, 0);   // R4 link on stack pointer
    run_op(16'h4E5F, 16'h0000, 0, 0);   // R6 unlink on stack pointer
    run_op(16'h4E52, 16'h000C, 3, 1);   // R3 R8 positive disp, busy poke
    run_op(16'h4E5A, 16'h0000, 1, 0);   // R5 unlink r2
    run_op(16'h4E5B, 16'h0000, 0, 0);   // R5 unlink r3 from preset memory
    // R1: opcode outside the family is taken but has no effect
    for (int i = 0; i < 8; i++) snap[i] = regs[i];
    @(negedge clk);
    op_code = 16'h4E71; op_valid = 1;
    @(negedge clk);
    op_valid = 0;
    check(busy == 0, "R1 no busy on foreign opcode", busy, 0);
    repeat (8) @(negedge clk);
    for (int i = 0; i < 8; i++)
      check(regs[i] === snap[i], "R1 regs untouched", regs[i], snap[i]);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule